// File: doc/BRIEF.md
# SAR converter serial control

This block is the digital sequencer of a 12-bit successive-approximation converter with a chip-select and serial-clock port. It runs on a free-running system clock. The active-low select and the serial clock are brought in through synchronisers, and their edges drive a state machine. A falling select edge stops tracking and starts a conversion. Each later falling serial-clock edge either shifts out a leading zero or registers one comparator decision. The decided bit goes onto the serial output in the same step, so there is no pipeline latency. The block drives the trial code to the capacitor DAC, a track/hold control, serial data with an output enable, a power-down flag and a data-valid flag.

Power management depends only on where the select line rises relative to the count of serial-clock falling edges. If the select rises inside a window early in the frame, the block enters power-down. To leave power-down, the host runs a dummy frame that lasts long enough. The block counts as powered again only when that dummy frame has ended and a fixed wake-up time, measured in system-clock cycles from the dummy frame's falling select edge, has passed.

States: `ST_OFF` (powered down, select high), `ST_DUMMY` (dummy frame in progress while powered down), `ST_WAKE` (dummy frame done, waiting for the wake-up timer), `ST_READY` (powered, select high), `ST_CONV` (frame in progress), `ST_QUIET` (16th falling edge seen, output released, select still low). The transitions are:
- OFF→DUMMY on select fall.
- DUMMY→OFF on select rise after fewer than 10 falling edges.
- DUMMY→WAKE on select rise after 10 or more falling edges, while the timer is still running.
- DUMMY→READY on the same rise when the timer has already expired.
- WAKE→READY when the timer expires.
- WAKE→DUMMY on select fall.
- READY→CONV on select fall.
- CONV→QUIET on the 16th falling edge.
- CONV→OFF on an abort inside the power-down window.
- CONV→READY on any other abort.
- QUIET→READY on select rise.

Top module: `sar_serial_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, the block is powered down: `pd_flag`=1, `sdo_oe`=0, `track`=0, `frame_valid`=0.
- R2: A falling `cs_n` in the powered idle state sets `track`=0 (hold), `sdo_oe`=1 with `sdo`=0, and `dac_code`=12'h800, which trials the MSB.
- R3: The serial word is 16 bits. `sdo` reads 0 after the select fall and after falling edges 1 to 3. After falling edge k, for k from 4 to 15, it carries result bit 15-k, so the MSB comes first.
- R4: Each decision keeps the trial bit when `cmp_in`=1, clears it when `cmp_in`=0, and sets the next lower bit as the new trial. With a comparator that reports input ≥ `dac_code`, the final `dac_code` and the serial result both equal the input code.
- R5: On the 16th falling `sclk` edge, `sdo_oe` goes to 0.
- R6: `track` stays 0 through falling edge 13. It goes to 1 on the first rising `sclk` edge after the 13th falling edge.
- R7: A rising `cs_n` at any point of a frame sets `sdo_oe` to 0 within three system-clock cycles.
- R8: If `cs_n` rises after 2 to 9 falling edges, the block powers down: `pd_flag`=1 and `track`=0. If it rises after 0, 1 or at least 10 edges, the block stays powered.
- R9: `frame_valid` is sampled at each select fall. It is 1 only if the previous frame reached its acquisition point, or if the block has just woken up. An abort before that point makes the next frame invalid.
- R10: From power-down, a select-low frame is a dummy frame: `sdo_oe` stays 0 and `frame_valid`=0. Fewer than 10 falling edges leaves the block powered down. 10 or more clears `pd_flag` once both the frame has ended and WAKE_CYC cycles have passed since its select fall. At that point `track`=1.
- R11: While `cs_n` is high, `sclk` edges change none of `sdo_oe`, `dac_code` or `track`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sclk | input | 1 | Serial clock (asynchronous, idles high) |
| cmp_in | input | 1 | Comparator result, 1 = input at or above trial code |
| dac_code | output | 12 | Trial code to the capacitor DAC |
| track | output | 1 | 1 = sample switch tracking, 0 = hold |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Output enable for the serial data driver |
| pd_flag | output | 1 | 1 while powered down or waking |
| frame_valid | output | 1 | Data of the current frame is valid |

## Verification
On every cycle, the checker enforces several invariants. The output driver is off and the block holds whenever power-down is flagged. Each frame starts with the driver on, a zero on the line, hold asserted and the MSB trial code. A select line held high always releases the driver. Leaving power-down always comes with tracking on. Only the bench scenarios can show the serial word content and the SAR result for specific input codes, the exact edge on which acquisition starts, the power-down window boundaries at edge counts 1, 2, 9 and 10, the valid flag after an aborted frame, and the wake-up timing.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_DUMMY,
        ST_WAKE,
        ST_READY,
        ST_CONV,
        ST_QUIET
    } ctl_state_e;
endpackage

// File: rtl/sar_edge_sync.sv
// Brings an asynchronous pin into the clk domain and flags its edges.
module sar_edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= RST_VAL;
        else        last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;
    assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/sar_approx.sv
// Successive-approximation register: one decision per step, MSB first.
module sar_approx #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         step,
    input  logic         cmp,
    output logic [W-1:0] code
);
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] code_q;
    logic [W-1:0] probe_q;   // one-hot position under trial

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            probe_q <= '0;
        end else if (start) begin
            code_q  <= TOP_BIT;
            probe_q <= TOP_BIT;
        end else if (step && (probe_q != '0)) begin
            code_q  <= (code_q & ~probe_q) | (cmp ? probe_q : '0) | (probe_q >> 1);
            probe_q <= probe_q >> 1;
        end
    end

    assign code = code_q;
endmodule

// File: rtl/sar_wake_timer.sv
// Counts system-clock cycles from a start pulse up to LIMIT and then holds.
module sar_wake_timer #(
    parameter int LIMIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int            CW  = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (start)       cnt <= '0;
        else if (cnt != LIM)  cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LIM);
endmodule

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl #(
    parameter int DATA_W      = 12,
    parameter int LEAD_ZEROS  = 4,
    parameter int PD_FIRST    = 2,
    parameter int PD_LAST     = 9,
    parameter int ACQ_EDGE    = 13,
    parameter int SYNC_STAGES = 2,
    parameter int CLK_HZ      = 200_000_000,
    parameter int WAKE_US     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              cmp_in,
    output logic [DATA_W-1:0] dac_code,
    output logic              track,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              pd_flag,
    output logic              frame_valid
);
    import sar_ctl_pkg::*;

    localparam int FRAME_LEN = LEAD_ZEROS + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam int WAKE_CYC  = (CLK_HZ / 1_000_000) * WAKE_US;

    localparam logic [CNT_W-1:0] C_PD_FIRST  = CNT_W'(PD_FIRST);
    localparam logic [CNT_W-1:0] C_PD_LAST   = CNT_W'(PD_LAST);
    localparam logic [CNT_W-1:0] C_WAKE_EDGE = CNT_W'(PD_LAST + 1);
    localparam logic [CNT_W-1:0] C_ACQ       = CNT_W'(ACQ_EDGE);
    localparam logic [CNT_W-1:0] C_DEC_FROM  = CNT_W'(LEAD_ZEROS - 1);
    localparam logic [CNT_W-1:0] C_DEC_TO    = CNT_W'(FRAME_LEN - 2);
    localparam logic [CNT_W-1:0] C_LAST_BIT  = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] C_SAT       = '1;

    logic cs_rise, cs_fall, sclk_rise, sclk_fall;
    logic wake_done, sar_start, sar_step;
    logic [CNT_W-1:0] edge_cnt;
    logic in_pd_window;
    ctl_state_e state, state_nx;

    sar_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .din(cs_n), .rise(cs_rise), .fall(cs_fall)
    );

    sar_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .din(sclk), .rise(sclk_rise), .fall(sclk_fall)
    );

    sar_wake_timer #(.LIMIT(WAKE_CYC)) u_wake (
        .clk(clk), .rst_n(rst_n), .start(sar_start_pd()), .expired(wake_done)
    );

    function automatic logic sar_start_pd();
        return (state == ST_OFF) && cs_fall;
    endfunction

    assign in_pd_window = (edge_cnt >= C_PD_FIRST) && (edge_cnt <= C_PD_LAST);
    assign sar_start    = (state == ST_READY) && cs_fall;
    assign sar_step     = (state == ST_CONV) && sclk_fall && !cs_rise &&
                          (edge_cnt >= C_DEC_FROM) && (edge_cnt <= C_DEC_TO);

    sar_approx #(.W(DATA_W)) u_sar (
        .clk(clk), .rst_n(rst_n), .start(sar_start), .step(sar_step),
        .cmp(cmp_in), .code(dac_code)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // Next-state decode; a select edge wins over a clock edge in the same cycle
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (cs_fall) state_nx = ST_DUMMY;
            ST_DUMMY: if (cs_rise) begin
                          if (edge_cnt < C_WAKE_EDGE) state_nx = ST_OFF;
                          else if (wake_done)         state_nx = ST_READY;
                          else                        state_nx = ST_WAKE;
                      end
            ST_WAKE:  if (cs_fall)        state_nx = ST_DUMMY;
                      else if (wake_done) state_nx = ST_READY;
            ST_READY: if (cs_fall) state_nx = ST_CONV;
            ST_CONV:  if (cs_rise)  state_nx = in_pd_window ? ST_OFF : ST_READY;
                      else if (sclk_fall && (edge_cnt == C_LAST_BIT)) state_nx = ST_QUIET;
            ST_QUIET: if (cs_rise) state_nx = ST_READY;
            default:  state_nx = ST_OFF;
        endcase
    end

    // Edge counter: falling serial-clock edges since the select fell
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            edge_cnt <= '0;
        else if (cs_fall)
            edge_cnt <= '0;
        else if (sclk_fall && (edge_cnt != C_SAT) &&
                 (state == ST_CONV || state == ST_DUMMY || state == ST_QUIET))
            edge_cnt <= edge_cnt + 1'b1;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            track       <= 1'b0;
            sdo         <= 1'b0;
            sdo_oe      <= 1'b0;
            frame_valid <= 1'b0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    track  <= 1'b0;
                    sdo_oe <= 1'b0;
                    if (cs_fall) frame_valid <= 1'b0;
                end
                ST_DUMMY: begin
                    sdo_oe <= 1'b0;
                    track  <= cs_rise && (edge_cnt >= C_WAKE_EDGE) && wake_done;
                end
                ST_WAKE: begin
                    sdo_oe <= 1'b0;
                    if (cs_fall) begin
                        frame_valid <= 1'b0;
                        track       <= 1'b0;
                    end else if (wake_done) begin
                        track <= 1'b1;
                    end
                end
                ST_READY: begin
                    if (cs_fall) begin
                        frame_valid <= track;
                        track       <= 1'b0;
                        sdo         <= 1'b0;
                        sdo_oe      <= 1'b1;
                    end
                end
                ST_CONV: begin
                    if (cs_rise) begin
                        sdo_oe <= 1'b0;
                        if (in_pd_window) track <= 1'b0;
                    end else if (sclk_fall) begin
                        if (edge_cnt == C_LAST_BIT)      sdo_oe <= 1'b0;
                        else if (edge_cnt >= C_DEC_FROM) sdo    <= cmp_in;
                        else                             sdo    <= 1'b0;
                    end else if (sclk_rise && (edge_cnt >= C_ACQ)) begin
                        track <= 1'b1;
                    end
                end
                ST_QUIET: begin
                    sdo_oe <= 1'b0;
                    if (sclk_rise && (edge_cnt >= C_ACQ)) track <= 1'b1;
                end
                default: begin
                    track  <= 1'b0;
                    sdo_oe <= 1'b0;
                end
            endcase
        end
    end

    // Combinational status output
    always_comb begin
        pd_flag = (state == ST_OFF) || (state == ST_DUMMY) || (state == ST_WAKE);
    end
endmodule

// File: rtl/sar_serial_ctrl_chk.sv
module sar_serial_ctrl_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic [DATA_W-1:0] dac_code,
    input logic              track,
    input logic              sdo,
    input logic              sdo_oe,
    input logic              pd_flag
);
    localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_state_R1: assert (pd_flag && !sdo_oe && !track);
        end
    end

    assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> (!track && !sdo && dac_code == TOP_BIT));

    assert_release_on_cs_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

    assert_quiet_in_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pd_flag |-> (!sdo_oe && !track));

    assert_wake_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_flag) |-> track);
endmodule

bind sar_serial_ctrl sar_serial_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dac_code(dac_code), .track(track),
    .sdo(sdo), .sdo_oe(sdo_oe), .pd_flag(pd_flag)
);

// File: tb/test_sar_serial_ctrl.sv
`timescale 1ns/1ps
module test_sar_serial_ctrl;
    localparam int HALF = 8;
    localparam int NVEC = 7;
    // {input code, expected 16-bit serial word}
    localparam logic [27:0] VEC [NVEC] = '{
        {12'hA5C, 16'h0A5C}, {12'h000, 16'h0000}, {12'hFFF, 16'h0FFF},
        {12'h800, 16'h0800}, {12'h7FF, 16'h07FF}, {12'h001, 16'h0001},
        {12'h555, 16'h0555}
    };

    logic clk = 1'b0;
    logic rst_n, cs_n, sclk, cmp_in;
    logic [11:0] dac_code, vin;
    logic track, sdo, sdo_oe, pd_flag, frame_valid;
    int n_chk = 0, n_fail = 0;

    logic [15:0] f_word;
    logic f_oe0, f_oe16, f_trk_pre, f_trk_post, f_valid, f_oe_end, f_pd_end, f_trk_end;
    logic [11:0] f_dac0;

    always #2.5 clk = ~clk;
    assign cmp_in = (vin >= dac_code);

    sar_serial_ctrl i_sar_serial_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .cmp_in(cmp_in),
        .dac_code(dac_code), .track(track), .sdo(sdo), .sdo_oe(sdo_oe),
        .pd_flag(pd_flag), .frame_valid(frame_valid)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input logic [11:0] v, input int nfall);
        vin = v;
        f_word = '0; f_oe16 = 1'b1; f_trk_pre = 1'b1; f_trk_post = 1'b0;
        cs_n = 1'b0;
        idle(HALF);
        f_word[15] = sdo; f_oe0 = sdo_oe; f_valid = frame_valid; f_dac0 = dac_code;
        for (int k = 1; k <= nfall; k++) begin
            sclk = 1'b0;
            idle(HALF);
            if (k <= 15) f_word[15-k] = sdo;
            if (k == 16) f_oe16 = sdo_oe;
            if (k == 13) f_trk_pre = track;
            sclk = 1'b1;
            idle(HALF);
            if (k == 13) f_trk_post = track;
        end
        cs_n = 1'b1;
        idle(6);
        f_oe_end = sdo_oe; f_pd_end = pd_flag; f_trk_end = track;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; vin = '0;
        idle(5);
        chk("R1", "pd_flag", pd_flag, 1);
        chk("R1", "sdo_oe", sdo_oe, 0);
        chk("R1", "track", track, 0);
        chk("R1", "frame_valid", frame_valid, 0);
        rst_n = 1'b1;
        idle(5);
        chk("R1", "pd_flag after release", pd_flag, 1);

        // R11: clock with select high while powered down
        for (int i = 0; i < 4; i++) begin sclk = 1'b0; idle(HALF); sclk = 1'b1; idle(HALF); end
        chk("R11", "sdo_oe idle clocks", sdo_oe, 0);

        // R10: too-short dummy frame keeps power-down
        run_frame(12'h000, 9);
        chk("R10", "dummy sdo_oe", f_oe0, 0);
        chk("R10", "dummy frame_valid", f_valid, 0);
        idle(400);
        chk("R10", "pd after short dummy", pd_flag, 1);

        // R10: dummy with 11 edges, timer still running at its end
        run_frame(12'h000, 11);
        chk("R10", "pd while waking", f_pd_end, 1);
        idle(100);
        chk("R10", "pd after wake time", pd_flag, 0);
        chk("R10", "track after wake", track, 1);

        // Vector table: full frames
        for (int i = 0; i < NVEC; i++) begin
            run_frame(VEC[i][27:16], 16);
            chk("R2", "oe at frame start", f_oe0, 1);
            chk("R2", "trial code at start", f_dac0, 12'h800);
            chk("R3", "serial word", f_word, VEC[i][15:0]);
            chk("R4", "final dac_code", dac_code, VEC[i][27:16]);
            chk("R5", "oe after 16th edge", f_oe16, 0);
            chk("R6", "track before acq", f_trk_pre, 0);
            chk("R6", "track after acq", f_trk_post, 1);
            chk("R9", "frame_valid", f_valid, 1);
        end

        // R7/R9: abort after 12 edges
        run_frame(12'h3C3, 12);
        chk("R7", "oe after abort", f_oe_end, 0);
        chk("R8", "pd after 12-edge abort", f_pd_end, 0);
        run_frame(12'h9A1, 16);
        chk("R9", "valid after early abort", f_valid, 0);
        chk("R3", "word after abort", f_word, 16'h09A1);
        run_frame(12'h9A1, 16);
        chk("R9", "valid after full frame", f_valid, 1);

        // R11: clocks with select high while powered
        for (int i = 0; i < 4; i++) begin sclk = 1'b0; idle(HALF); sclk = 1'b1; idle(HALF); end
        chk("R11", "dac_code unchanged", dac_code, 12'h9A1);
        chk("R11", "sdo_oe unchanged", sdo_oe, 0);
        chk("R11", "track unchanged", track, 1);

        // R8 boundaries
        run_frame(12'h111, 1);
        chk("R8", "pd after 1 edge", f_pd_end, 0);
        run_frame(12'h222, 10);
        chk("R8", "pd after 10 edges", f_pd_end, 0);
        run_frame(12'h333, 2);
        chk("R8", "pd after 2 edges", f_pd_end, 1);
        chk("R8", "track after 2-edge abort", f_trk_end, 0);
        chk("R7", "oe after 2-edge abort", f_oe_end, 0);

        // R10: long dummy, timer already expired at select rise
        run_frame(12'h000, 16);
        chk("R10", "long dummy oe", f_oe0, 0);
        chk("R10", "pd after long dummy", f_pd_end, 0);
        run_frame(12'h4D2, 5);
        chk("R8", "pd after 5 edges", f_pd_end, 1);
        chk("R3", "MSB on 4th edge", f_word[11], 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule